// File: doc/BRIEF.md
# Flash Status-Polling Completion Checker

This block runs on the host side of a parallel flash interface. After a program or erase command has been sent to the flash, it decides whether that operation has finished. A single start pulse hands it the expected data byte and the address to poll. For a program, that is the byte being written and its address. For an erase, it is all-ones and any address inside a sector being erased. The checker then reads that address over and over through a level-request / valid-response read port. After each read it looks at two status bits: the completion bit (bit 7) and the timeout flag (bit 5).

The flash drives the completion bit to the true data value only once the operation is over. That bit can settle earlier than the lower bits. So after bit 7 matches, the checker issues one more confirming read and returns that byte as the trusted result. The timeout flag can rise in the same read in which bit 7 flips. When the flag is seen with bit 7 still wrong, the checker therefore reads once more before it gives up.

A parameter sets an optional limit on how many plain busy polls are allowed. Completion is reported with a single-cycle done pulse. The pass/fail result and the final byte come with it and stay held.

Top module: `pollChecker`

## Requirements
- R1: With the block idle, `startI` captures `addrI` and bit 7 of `expDataI`. From the next cycle, `busyO` and `rdReqO` are high and `rdAddrO` equals the captured address until the next accepted start.
- R2: A read is accepted only in a cycle where both `rdReqO` and `rdValidI` are high. `rdValidI` has no effect while `rdReqO` is low.
- R3: If an accepted poll has bit 7 equal to the expected bit 7, exactly one more read follows. That read's byte is reported on `dataO` with `passO`=1.
- R4: If an accepted poll has bit 7 different from the expected bit 7 and bit 5 = 0, the block issues another poll.
- R5: If an accepted poll has bit 7 wrong and bit 5 = 1, the block issues one recheck read. If bit 7 matches on that read, one confirming read follows and the result is pass with the confirming byte.
- R6: If the recheck read's bit 7 is still wrong, the result is fail (`failO`=1) and `dataO` holds the recheck byte. No further read is made.
- R7: An erase is checked by supplying expected data 8'hFF, so the block waits for bit 7 = 1.
- R8: When `MAX_POLLS` > 0, the `MAX_POLLS`-th poll in a row that has bit 7 wrong and bit 5 = 0 ends the run as fail, with `dataO` set to that byte. With `MAX_POLLS` = 0 there is no limit.
- R9: `doneO` is high for exactly one cycle, the cycle after the final read is accepted. In that cycle `busyO` is already low and exactly one of `passO` / `failO` is high. The result and `dataO` are held until the next accepted start.
- R10: `startI` is ignored while `busyO` is high. It changes neither the polled address, the expected bit, nor the number or outcome of reads.
- R11: After reset, `busyO`, `rdReqO`, `doneO`, `passO` and `failO` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startI | input | 1 | Start pulse, taken only while idle |
| expDataI | input | DATA_W | Expected byte (all-ones for erase) |
| addrI | input | ADDR_W | Address to poll |
| rdReqO | output | 1 | Read request, high for as long as reads are wanted |
| rdAddrO | output | ADDR_W | Read address |
| rdValidI | input | 1 | Read data valid; with `rdReqO` completes one read |
| rdDataI | input | DATA_W | Read data byte |
| busyO | output | 1 | Check in progress |
| doneO | output | 1 | One-cycle completion pulse |
| passO | output | 1 | Operation completed successfully (held) |
| failO | output | 1 | Operation failed (held) |
| dataO | output | DATA_W | Confirmed byte, or last status byte on failure (held) |

## Verification
The assertions assume that `startI` and `rdValidI` are clean synchronous levels. They also assume that a response is offered only as a read outcome and is never withheld forever. The stimulus drives every input on the falling edge. It raises `rdValidI` at random only while `rdReqO` is seen high, apart from a deliberate idle-time burst that probes R2. Each response byte comes from a per-run script built so that bit 7 and bit 5 pick one of the intended paths: immediate match, busy polls, timeout-flag recheck, or limit. The start input is pulsed once in the middle of every run so that R10 is exercised without breaking the response ordering.

// File: rtl/pollPkg.sv
package pollPkg;
  localparam int STAT_BIT = 7;  // completion bit in status byte
  localparam int TOUT_BIT = 5;  // timeout flag in status byte

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_POLL,
    ST_RECHK,
    ST_CONF
  } pollState_t;

  typedef struct packed {
    logic load;
    logic cntInc;
    logic finPass;
    logic finFail;
  } pollStrobe_t;
endpackage

// File: rtl/pollCtrl.sv
module pollCtrl
  import pollPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startI,
  input  logic        rdValidI,
  input  logic        dq7Match,
  input  logic        dq5Set,
  input  logic        limitHit,
  output pollStrobe_t strb,
  output logic        busyO,
  output logic        rdReqO
);
  pollState_t state, nextState;
  logic accept;

  assign busyO  = (state != ST_IDLE);
  assign rdReqO = busyO;
  assign accept = rdReqO && rdValidI;

  always_comb begin
    nextState = state;
    strb      = '0;
    unique case (state)
      ST_IDLE: begin
        if (startI) begin
          strb.load = 1'b1;
          nextState = ST_POLL;
        end
      end
      ST_POLL: begin
        if (accept) begin
          if (dq7Match) begin
            nextState = ST_CONF;
          end else if (dq5Set) begin
            nextState = ST_RECHK;
          end else if (limitHit) begin
            strb.finFail = 1'b1;
            nextState    = ST_IDLE;
          end else begin
            strb.cntInc = 1'b1;
          end
        end
      end
      ST_RECHK: begin
        if (accept) begin
          if (dq7Match) begin
            nextState = ST_CONF;
          end else begin
            strb.finFail = 1'b1;
            nextState    = ST_IDLE;
          end
        end
      end
      ST_CONF: begin
        if (accept) begin
          strb.finPass = 1'b1;
          nextState    = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end
endmodule

// File: rtl/pollData.sv
module pollData
  import pollPkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 20,
  parameter int MAX_POLLS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  pollStrobe_t       strb,
  input  logic [DATA_W-1:0] expDataI,
  input  logic [ADDR_W-1:0] addrI,
  input  logic [DATA_W-1:0] rdDataI,
  output logic              dq7Match,
  output logic              dq5Set,
  output logic              limitHit,
  output logic [ADDR_W-1:0] rdAddrO,
  output logic              doneO,
  output logic              passO,
  output logic              failO,
  output logic [DATA_W-1:0] dataO
);
  localparam int CNT_W = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;

  logic expBit;
  logic [ADDR_W-1:0] addrReg;

  assign dq7Match = (rdDataI[STAT_BIT] == expBit);
  assign dq5Set   = rdDataI[TOUT_BIT];
  assign rdAddrO  = addrReg;

  generate
    if (MAX_POLLS > 0) begin : gLimit
      logic [CNT_W-1:0] pollCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)            pollCnt <= '0;
        else if (strb.load)   pollCnt <= '0;
        else if (strb.cntInc) pollCnt <= pollCnt + 1'b1;
      end
      assign limitHit = (pollCnt == CNT_W'(MAX_POLLS - 1));
    end else begin : gNoLimit
      assign limitHit = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expBit  <= 1'b0;
      addrReg <= '0;
      doneO   <= 1'b0;
      passO   <= 1'b0;
      failO   <= 1'b0;
      dataO   <= '0;
    end else begin
      doneO <= strb.finPass || strb.finFail;
      if (strb.load) begin
        expBit  <= expDataI[STAT_BIT];
        addrReg <= addrI;
        passO   <= 1'b0;
        failO   <= 1'b0;
      end
      if (strb.finPass || strb.finFail) begin
        passO <= strb.finPass;
        failO <= strb.finFail;
        dataO <= rdDataI;
      end
    end
  end
endmodule

// File: rtl/pollChecker.sv
module pollChecker
  import pollPkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 20,
  parameter int MAX_POLLS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startI,
  input  logic [DATA_W-1:0] expDataI,
  input  logic [ADDR_W-1:0] addrI,
  output logic              rdReqO,
  output logic [ADDR_W-1:0] rdAddrO,
  input  logic              rdValidI,
  input  logic [DATA_W-1:0] rdDataI,
  output logic              busyO,
  output logic              doneO,
  output logic              passO,
  output logic              failO,
  output logic [DATA_W-1:0] dataO
);
  pollStrobe_t strb;
  logic dq7Match, dq5Set, limitHit;

  pollCtrl uCtrl (
    .clk(clk), .rstN(rstN), .startI(startI), .rdValidI(rdValidI),
    .dq7Match(dq7Match), .dq5Set(dq5Set), .limitHit(limitHit),
    .strb(strb), .busyO(busyO), .rdReqO(rdReqO)
  );

  pollData #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .MAX_POLLS(MAX_POLLS)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .expDataI(expDataI), .addrI(addrI),
    .rdDataI(rdDataI), .dq7Match(dq7Match), .dq5Set(dq5Set), .limitHit(limitHit),
    .rdAddrO(rdAddrO), .doneO(doneO), .passO(passO), .failO(failO), .dataO(dataO)
  );
endmodule

// File: rtl/pollChecker_chk.sv
module pollChecker_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic              startI,
  input logic [ADDR_W-1:0] addrI,
  input logic              rdReqO,
  input logic [ADDR_W-1:0] rdAddrO,
  input logic              rdValidI,
  input logic              busyO,
  input logic              doneO,
  input logic              passO,
  input logic              failO
);
  // R1
  start_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busyO && startI) |=> (busyO && rdReqO && rdAddrO == $past(addrI)));

  // R10
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busyO && startI) |=> $stable(rdAddrO));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneO |=> !doneO);

  // R9
  result_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneO |-> ((passO ^ failO) && !busyO));

  // R2
  done_after_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneO) |-> $past(rdReqO && rdValidI));
endmodule

bind pollChecker pollChecker_chk #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .startI(startI), .addrI(addrI), .rdReqO(rdReqO),
  .rdAddrO(rdAddrO), .rdValidI(rdValidI), .busyO(busyO), .doneO(doneO),
  .passO(passO), .failO(failO)
);

// File: tb/sim_pollChecker.sv
module sim_pollChecker;
  localparam int DW = 8;
  localparam int AW = 20;
  localparam int MAXP = 16;
  localparam int RN = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startI = 1'b0;
  logic [DW-1:0] expDataI = '0;
  logic [AW-1:0] addrI = '0;
  logic rdValidI = 1'b0;
  logic [DW-1:0] rdDataI = '0;
  logic rdReqO, busyO, doneO, passO, failO;
  logic [AW-1:0] rdAddrO;
  logic [DW-1:0] dataO;

  int nChecks = 0;
  int nFails = 0;
  int cycles = 0;
  logic [7:0] resp [RN];

  always #10 clk = ~clk;

  pollChecker #(.DATA_W(DW), .ADDR_W(AW), .MAX_POLLS(MAXP)) u0 (
    .clk(clk), .rstN(rstN), .startI(startI), .expDataI(expDataI), .addrI(addrI),
    .rdReqO(rdReqO), .rdAddrO(rdAddrO), .rdValidI(rdValidI), .rdDataI(rdDataI),
    .busyO(busyO), .doneO(doneO), .passO(passO), .failO(failO), .dataO(dataO)
  );

  task automatic finish();
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nFails++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
      finish();
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Reference outcome from the requirements, walking the scripted responses
  function automatic void predict(input logic [7:0] e, output bit pPass,
                                  output logic [7:0] pData, output int pReads);
    int cnt = 0;
    int i = 0;
    pPass = 0; pData = '0; pReads = 0;
    while (i < RN - 3) begin
      if (resp[i][7] == e[7]) begin            // R3
        pPass = 1; pData = resp[i+1]; pReads = i + 2; return;
      end else if (resp[i][5]) begin           // R5 / R6
        if (resp[i+1][7] == e[7]) begin
          pPass = 1; pData = resp[i+2]; pReads = i + 3;
        end else begin
          pPass = 0; pData = resp[i+1]; pReads = i + 2;
        end
        return;
      end else begin                           // R4 / R8
        cnt++;
        if (MAXP > 0 && cnt == MAXP) begin
          pPass = 0; pData = resp[i]; pReads = i + 1; return;
        end
      end
      i++;
    end
  endfunction

  function automatic logic [7:0] busyByte(input logic [7:0] e, input bit tflag);
    logic [7:0] b = 8'($urandom);
    b[7] = ~e[7];
    b[5] = tflag;
    return b;
  endfunction

  // mode 0: k busy then match; 1: k busy, flag, recheck match;
  // 2: k busy, flag, recheck miss; 3: limit
  task automatic script(input logic [7:0] e, input int mode, input int k);
    int p = 0;
    for (int i = 0; i < RN; i++) resp[i] = 8'($urandom);
    for (int i = 0; i < k; i++) resp[p++] = busyByte(e, 1'b0);
    case (mode)
      0: begin resp[p] = 8'($urandom); resp[p][7] = e[7]; end
      1: begin resp[p++] = busyByte(e, 1'b1); resp[p] = 8'($urandom); resp[p][7] = e[7]; end
      2: begin resp[p++] = busyByte(e, 1'b1); resp[p] = busyByte(e, 1'($urandom)); end
      default: for (int i = p; i < MAXP + 2; i++) resp[i] = busyByte(e, 1'b0);
    endcase
  endtask

  task automatic runCase(input logic [7:0] e, input string tag);
    bit pPass, got, addrOk;
    logic [7:0] pData;
    int pReads, idx;
    logic [AW-1:0] addr;
    predict(e, pPass, pData, pReads);
    addr = AW'($urandom);
    idx = 0; got = 0; addrOk = 1;
    @(negedge clk);
    expDataI = e; addrI = addr; startI = 1'b1;
    @(negedge clk);
    startI = 1'b0; expDataI = ~e; addrI = ~addr;
    check(busyO && rdReqO, "R1", {tag, " busy after start"}, {busyO, rdReqO}, 3);
    for (int it = 0; it < 400; it++) begin
      startI = 1'b0;
      if (doneO) begin got = 1; break; end
      if (rdAddrO != addr) addrOk = 0;
      if (it == 2) startI = 1'b1;                 // R10 start while busy
      if (rdReqO && ($urandom % 10) < 7) begin
        rdValidI = 1'b1; rdDataI = resp[idx]; idx++;
      end
      @(negedge clk);
      rdValidI = 1'b0;
    end
    startI = 1'b0;
    check(got, "R9", {tag, " done seen"}, got, 1);
    check(busyO == 0, "R9", {tag, " busy low at done"}, busyO, 0);
    check(passO == pPass && failO == !pPass, pPass ? "R3" : "R6",
          {tag, " pass/fail"}, {passO, failO}, {pPass, !pPass});
    check(dataO == pData, "R3", {tag, " dataO"}, dataO, pData);
    check(idx == pReads, "R4", {tag, " read count"}, idx, pReads);
    check(addrOk, "R10", {tag, " address held"}, addrOk, 1);
    @(negedge clk);
    check(doneO == 0 && (passO == pPass), "R9", {tag, " done one cycle, result held"},
          {doneO, passO}, {1'b0, pPass});
  endtask

  initial begin
    logic [7:0] e;
    int mode;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R11 reset state
    check(!busyO && !rdReqO && !doneO && !passO && !failO, "R11", "reset outputs",
          {busyO, rdReqO, doneO, passO, failO}, 0);
    rstN = 1'b1;
    // R2 stray valid while idle
    @(negedge clk);
    rdValidI = 1'b1; rdDataI = 8'h80;
    repeat (3) @(negedge clk);
    rdValidI = 1'b0;
    check(!busyO && !doneO && !passO && !failO, "R2", "stray valid ignored",
          {busyO, doneO, passO, failO}, 0);

    // directed corners
    script(8'hFF, 0, 0);    runCase(8'hFF, "R7 erase immediate");
    script(8'hFF, 0, 5);    runCase(8'hFF, "R7 erase after busy");
    script(8'h3C, 1, 0);    runCase(8'h3C, "R5 flag first read");
    script(8'hA5, 2, 3);    runCase(8'hA5, "R6 recheck miss");
    script(8'h11, 3, 0);    runCase(8'h11, "R8 limit");
    script(8'h90, 0, MAXP - 1); runCase(8'h90, "R8 last poll matches");

    // constrained random
    for (int n = 0; n < 60; n++) begin
      e = (($urandom % 4) == 0) ? 8'hFF : 8'($urandom);
      mode = $urandom % 4;
      script(e, mode, $urandom % (MAXP - 1));
      runCase(e, "random");
    end
    finish();
  end
endmodule